// File: doc/BRIEF.md
# Serial SRAM Host Engine

This block is the host side of a link to a serial static RAM that speaks a four-wire SPI protocol. A client issues one request at a time on a valid/ready command port: set the memory's mode byte, read the mode byte back, write a burst of bytes starting at an address, or read a burst starting at an address. The engine frames each request as a single chip-select-low transaction. It shifts out the instruction, then the address, then the payload, and it captures the bytes the memory returns.

Write payload comes in on a byte-wide valid/ready stream and read results go out on another. Neither stream needs to keep pace with the serial link. When the client is late, the engine parks the serial clock low between bytes and waits. The serial clock runs in SPI mode 0 with the most significant bit first. Its half period is a run-time count of system clocks, so a full serial period is always an even number of system clocks.

Top module: `sram_spi_host`

## Requirements
- R1: The first byte of every frame is the instruction for the request on `cmd_op`: op 0 (mode write) sends 0x01, op 1 (mode read) sends 0x05, op 2 (data write) sends 0x02, op 3 (data read) sends 0x03. Every byte goes out most significant bit first.
- R2: A data frame carries the instruction, then the address high byte, then the address low byte, then the payload bytes, for 3 + N bytes in total. A mode frame carries the instruction and one mode byte, for 2 bytes in total.
- R3: `spi_cs_n` stays low from the first bit of a frame until after the last bit. Between frames it stays high for at least two half periods, that is, one serial clock period.
- R4: `spi_sclk` idles low. Each high phase lasts exactly `clk_half_div` system clocks, where a value of 0 counts as 1. `spi_mosi` does not change while `spi_sclk` is high.
- R5: A mode write of 0x41 followed by a mode read delivers 0x41 on the read stream.
- R6: A burst write of N bytes followed by a burst read of N bytes at the same address returns the same bytes in order, for any N.
- R7: A read byte on `rd_data` stays unchanged, with `rd_valid` held high, until it is accepted. Back-pressure on `rd_ready` or `wr_valid` stalls the link without losing or repeating bytes.
- R8: `busy` rises in the cycle after a request is accepted and falls only after `spi_cs_n` has returned high and the inter-frame gap has elapsed. `cmd_ready` is low whenever `busy` is high.
- R9: During and after reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0, `cmd_ready` is 1 and `rd_valid` is 0.
- R10: A data request with length 0 moves exactly one payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_half_div | input | DIV_W | Serial clock half period in system clocks (0 counts as 1) |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Engine can accept a request |
| cmd_op | input | 2 | 0 mode write, 1 mode read, 2 data write, 3 data read |
| cmd_addr | input | 8*ADDR_BYTES | Start address for data requests |
| cmd_len | input | LEN_W | Payload byte count for data requests (0 means 1) |
| cmd_mode | input | 8 | Mode byte for a mode write |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Engine takes the write stream byte |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Client takes the read stream byte |
| rd_data | output | 8 | Read stream byte |
| busy | output | 1 | Request in progress |
| spi_cs_n | output | 1 | Memory chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The bench sweeps the divider over three values and the burst length from the zero case up to ten bytes, against a behavioural memory that decodes the frames. A wrong length count would show up as a frame byte total off by one, or as a zero-length request that hangs or sends nothing. Off-by-one sampling or a missing pre-load of the first read bit would corrupt every read-back byte and the mode read. The client streams are throttled in fixed patterns. An engine that kept clocking while the read stream was full would overwrite or drop bytes, and one that let `rd_data` move while stalled would be caught by the hold monitor. Monitors also measure every serial high phase and every chip-select gap, so a divider that is off by one, or a chip select that comes back too early, gets flagged.

// File: rtl/sram_spi_pkg.sv
// Shared types for the serial SRAM host engine: request codes,
// controller states and the request-to-instruction mapping.
package sram_spi_pkg;

    typedef enum logic [1:0] {
        OP_MODE_WR = 2'd0,
        OP_MODE_RD = 2'd1,
        OP_DATA_WR = 2'd2,
        OP_DATA_RD = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT,
        ST_NEXT,
        ST_TAIL,
        ST_GAP
    } state_e;

    // Instruction byte that opens a frame for each request kind.
    function automatic logic [7:0] instr_of(op_e op);
        case (op)
            OP_MODE_WR: return 8'h01;
            OP_MODE_RD: return 8'h05;
            OP_DATA_WR: return 8'h02;
            default:    return 8'h03;
        endcase
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
// Half-period timer: while enabled, pulses tick once every
// half_div system clocks (0 treated as 1). Restarts from zero when
// disabled. Assumes half_div is stable while enabled.
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick    = en && (cnt >= div_eff - 1'b1);

    // Count system clocks inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R4: the count never runs past the half period while enabled.
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en && $stable(half_div) |-> cnt < div_eff);
endmodule

// File: rtl/spi_byte_shift.sv
// Byte shifter for SPI mode 0: the transmit byte is loaded with its
// MSB on the data line, MISO is sampled on each rise strobe and the
// next bit is shifted out on each fall strobe.
module spi_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       rise,
    input  logic       fall,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_sr;

    assign mosi = tx_sr[7];

    // Transmit register: load a new byte or move to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_sr <= '0;
        else if (load) tx_sr <= load_byte;
        else if (fall) tx_sr <= {tx_sr[6:0], 1'b0};
    end

    // Receive register: gather one MISO bit per rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_byte <= '0;
        else if (rise) rx_byte <= {rx_byte[6:0], miso};
    end
endmodule

// File: rtl/sram_spi_host.sv
// Serial SRAM host engine. Takes one request at a time and runs it
// as a single chip-select-low frame: instruction, address bytes for
// data requests, then payload. The serial clock is parked low between
// bytes whenever a client stream is not ready. Assumes clk_half_div
// does not change while busy.
module sram_spi_host
    import sram_spi_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 8,
    parameter int ADDR_BYTES = 2,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_half_div,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [7:0]        cmd_mode,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    input  logic              spi_miso,
    output logic              spi_mosi
);
    localparam int CNT_W = LEN_W + 2;

    state_e            state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        mode_q;
    logic [CNT_W-1:0]  total_q, byte_idx, hdr_cnt, pay_len;
    logic [2:0]        bit_cnt;
    logic              sclk_q, cs_n_q, gap_cnt;
    logic              tick, rise, fall, accept, is_pay, op_reads, go, push;
    logic              need_wr, need_rd, cmd_is_data;
    logic [7:0]        addr_byte, next_tx, load_byte, rx_byte;

    assign cmd_ready   = (state == ST_IDLE);
    assign busy        = !cmd_ready;
    assign accept      = cmd_valid && cmd_ready;
    assign cmd_is_data = cmd_op[1];
    assign pay_len     = (cmd_len == '0) ? CNT_W'(1) : CNT_W'(cmd_len);
    assign hdr_cnt     = (op_q == OP_DATA_WR || op_q == OP_DATA_RD)
                         ? CNT_W'(1 + ADDR_BYTES) : CNT_W'(1);
    assign is_pay      = byte_idx >= hdr_cnt;
    assign op_reads    = (op_q == OP_MODE_RD) || (op_q == OP_DATA_RD);
    assign rise        = (state == ST_BIT) && tick && !sclk_q;
    assign fall        = (state == ST_BIT) && tick && sclk_q;
    assign push        = fall && (bit_cnt == 3'd7) && is_pay && op_reads;
    assign need_wr     = (state == ST_NEXT) && is_pay && (op_q == OP_DATA_WR);
    assign need_rd     = (state == ST_NEXT) && is_pay && op_reads;
    assign go          = (state == ST_NEXT) && (!need_wr || wr_valid) && (!need_rd || !rd_valid);
    assign wr_ready    = need_wr;
    assign spi_cs_n    = cs_n_q;
    assign spi_sclk    = sclk_q;

    // Pick the address byte that belongs at the current header slot.
    always_comb begin
        addr_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (byte_idx == CNT_W'(k + 1)) addr_byte = addr_q[ADDR_W-1-8*k -: 8];
    end

    // Choose the next byte to shift: address, mode byte, write data or filler.
    always_comb begin
        if (!is_pay)                  next_tx = addr_byte;
        else if (op_q == OP_MODE_WR)  next_tx = mode_q;
        else if (op_q == OP_DATA_WR)  next_tx = wr_data;
        else                          next_tx = 8'h00;
        load_byte = accept ? instr_of(op_e'(cmd_op)) : next_tx;
    end

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state == ST_BIT || state == ST_TAIL || state == ST_GAP),
        .half_div (clk_half_div),
        .tick     (tick)
    );

    spi_byte_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept || go),
        .load_byte (load_byte),
        .rise      (rise),
        .fall      (fall),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte)
    );

    // Frame sequencer: accept, shift bytes, stall, release select, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_MODE_WR;
            addr_q   <= '0;
            mode_q   <= '0;
            total_q  <= '0;
            byte_idx <= '0;
            bit_cnt  <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            gap_cnt  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    op_q     <= op_e'(cmd_op);
                    addr_q   <= cmd_addr;
                    mode_q   <= cmd_mode;
                    total_q  <= cmd_is_data ? CNT_W'(1 + ADDR_BYTES) + pay_len : CNT_W'(2);
                    byte_idx <= '0;
                    bit_cnt  <= '0;
                    cs_n_q   <= 1'b0;
                    state    <= ST_BIT;
                end
                ST_BIT: if (tick) begin
                    sclk_q <= !sclk_q;
                    if (sclk_q) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= (byte_idx + 1'b1 == total_q) ? ST_TAIL : ST_NEXT;
                        end
                    end
                end
                ST_NEXT: if (go) state <= ST_BIT;
                ST_TAIL: if (tick) begin
                    cs_n_q  <= 1'b1;
                    gap_cnt <= 1'b0;
                    state   <= ST_GAP;
                end
                ST_GAP: if (tick) begin
                    if (gap_cnt) state <= ST_IDLE;
                    gap_cnt <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read stream holding register: fill on a completed read byte, clear on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (push) begin
            rd_valid <= 1'b1;
            rd_data  <= rx_byte;
        end else if (rd_valid && rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    // R8: an accepted request drops chip select and reports busy next cycle.
    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy && !spi_cs_n);
    // R4: the serial clock stays low while chip select is high.
    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R4: data out is steady through each serial high phase.
    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk && $past(spi_sclk) |-> $stable(spi_mosi));
    // R7: a pending read byte is held until taken.
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
    // R7: write data is only taken while the serial clock is parked low.
    assert_wr_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_sclk && !spi_cs_n);
    // R3: a released chip select stays high for more than one cycle.
    assert_cs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/sram_spi_host_bench.sv
module sram_spi_host_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] clk_half_div = 8'd1;
    logic       cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [15:0] cmd_addr = '0;
    logic [7:0] cmd_len = '0, cmd_mode = '0;
    logic       wr_valid = 1'b0, wr_ready;
    logic [7:0] wr_data = '0;
    logic       rd_valid, rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic       busy, spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    always #2 clk = ~clk;

    sram_spi_host u_sram_spi_host (
        .clk(clk), .rst_n(rst_n), .clk_half_div(clk_half_div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_mode(cmd_mode),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_miso(spi_miso), .spi_mosi(spi_mosi)
    );

    int n_checks = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int addr, input int k);
        return 8'((addr * 3 + k * 29 + 5) & 255);
    endfunction

    // Behavioural serial memory: decodes frames, sequential addressing.
    logic [7:0]  mem [0:1023];
    logic [7:0]  s_mode = '0, s_sh = '0, s_out = '0, s_op = '0, fr_op = '0;
    logic [15:0] s_addr = '0;
    int          s_bits = 0, s_bytes = 0, fr_bytes = 0;

    initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

    always @(negedge spi_cs_n) begin s_bits = 0; s_bytes = 0; end
    always @(posedge spi_cs_n) begin fr_bytes = s_bytes; fr_op = s_op; end

    always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
        s_sh = {s_sh[6:0], spi_mosi};
        s_bits++;
        if (s_bits == 8) begin
            s_bits = 0;
            if (s_bytes == 0) begin
                s_op = s_sh;
                if (s_sh == 8'h05) s_out = s_mode;
            end else if (s_op == 8'h01) begin
                if (s_bytes == 1) s_mode = s_sh;
            end else if (s_op == 8'h02 || s_op == 8'h03) begin
                if (s_bytes == 1) s_addr[15:8] = s_sh;
                else if (s_bytes == 2) s_addr[7:0] = s_sh;
                else if (s_op == 8'h02) begin mem[s_addr[9:0]] = s_sh; s_addr++; end
                if (s_op == 8'h03 && s_bytes >= 2) begin s_out = mem[s_addr[9:0]]; s_addr++; end
            end
            s_bytes++;
        end
    end

    always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
        spi_miso = s_out[7];
        s_out = {s_out[6:0], 1'b0};
    end

    // Timing monitors for serial high phase, select gap and data stability.
    int cur_div = 1, hi_run = 0, cs_run = 0, bad_hi = 0, bad_gap = 0, bad_mosi = 0;
    bit seen = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) if (rst_n) begin
        if (spi_sclk) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != cur_div) bad_hi++;
            hi_run = 0;
        end
        if (spi_cs_n) cs_run++;
        else begin
            if (seen && cs_run > 0 && cs_run < 2 * cur_div) bad_gap++;
            seen = 1;
            cs_run = 0;
        end
        if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) bad_mosi++;
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
    end

    int cyc = 0, bad_hold = 0;
    logic [7:0] got [0:15];

    task automatic do_cmd(input int op, input int addr, input int len, input int mode);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_addr  = 16'(addr);
        cmd_len   = 8'(len);
        cmd_mode  = 8'(mode);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && !cmd_ready, "R8", int'(busy), 1);
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R8", int'(spi_cs_n), 1);
    endtask

    // Write stream source with a stall pattern (R7).
    task automatic feed(input int n, input int addr);
        for (int k = 0; k < n; k++) begin
            forever begin
                @(negedge clk);
                cyc++;
                wr_valid = (cyc % 4 != 1);
                wr_data  = pat(addr, k);
                if (wr_valid && wr_ready) break;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Read stream sink with back-pressure; records bytes and hold violations (R7).
    task automatic collect(input int n);
        int k = 0;
        bit stalled = 0;
        logic [7:0] held = '0;
        while (k < n) begin
            @(negedge clk);
            cyc++;
            if (stalled && rd_valid && rd_data !== held) bad_hold++;
            rd_ready = (cyc % 3 != 0);
            if (rd_valid) begin
                if (rd_ready) begin got[k] = rd_data; k++; stalled = 0; end
                else begin stalled = 1; held = rd_data; end
            end
        end
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R9", int'({spi_cs_n, spi_sclk}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && cmd_ready && !rd_valid, "R9", int'({busy, cmd_ready, rd_valid}), 2);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R9", int'({spi_cs_n, spi_sclk}), 2);

        for (int div = 1; div <= 3; div++) begin
            cur_div = div;
            clk_half_div = 8'(div);
            repeat (20) @(negedge clk);

            do_cmd(0, 0, 0, 'h41);
            wait_done();
            chk(fr_op == 8'h01, "R1", int'(fr_op), 'h01);
            chk(fr_bytes == 2, "R2", fr_bytes, 2);

            fork
                do_cmd(1, 0, 0, 0);
                collect(1);
            join
            wait_done();
            chk(fr_op == 8'h05, "R1", int'(fr_op), 'h05);
            chk(fr_bytes == 2, "R2", fr_bytes, 2);
            chk(got[0] == 8'h41, "R5", int'(got[0]), 'h41);

            for (int li = 0; li < 8; li++) begin
                int len  = (li == 7) ? 10 : li;
                int n    = (len == 0) ? 1 : len;
                int addr = div * 256 + li * 16 + 3;
                fork
                    do_cmd(2, addr, len, 0);
                    feed(n, addr);
                join
                wait_done();
                chk(fr_op == 8'h02, "R1", int'(fr_op), 'h02);
                if (len == 0) chk(fr_bytes == 4, "R10", fr_bytes, 4);
                else          chk(fr_bytes == 3 + n, "R2", fr_bytes, 3 + n);

                fork
                    do_cmd(3, addr, len, 0);
                    collect(n);
                join
                wait_done();
                chk(fr_op == 8'h03, "R1", int'(fr_op), 'h03);
                if (len == 0) chk(fr_bytes == 4, "R10", fr_bytes, 4);
                else          chk(fr_bytes == 3 + n, "R2", fr_bytes, 3 + n);
                for (int k = 0; k < n; k++)
                    chk(got[k] == pat(addr, k), "R6", int'(got[k]), int'(pat(addr, k)));
                chk(bad_hold == 0, "R7", bad_hold, 0);
            end
        end

        chk(bad_hi == 0, "R4", bad_hi, 0);
        chk(bad_mosi == 0, "R4", bad_mosi, 0);
        chk(bad_gap == 0, "R3", bad_gap, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R8 watchdog expired, busy=%0d expected 0", busy);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule